// File: doc/BRIEF.md
# Asynchronous Parallel ROM Read Sequencer

This block sits on the host side of an external asynchronous parallel ROM. The ROM holds 16-bit words and takes an 18-bit address. The host raises a one-cycle request together with an address. The sequencer then drives the address onto the ROM pins and pulls the active-low device select down. It pulls the active-low read strobe down later, so that the strobe-to-data delay ends at the same time as the address-to-data delay. After a counted number of clock cycles the word on the data pins is registered and returned with a one-cycle valid pulse.

All of the ROM's delays are given as parameters in nanoseconds, along with the clock period. The block turns each one into a whole number of cycles by rounding up. After a read it releases both enables together, one cycle after the capture. It then keeps its busy output high for the ROM's output-float time, so that no other driver can be enabled on the shared data bus while the ROM pins are still driven.

Top module: `rom_read_ctrl`

## Requirements
- R1: During and right after reset, rom_ce_n and rom_oe_n are 1, busy is 0 and rvalid is 0.
- R2: A request sampled while busy is 0 makes rom_ce_n go 0, rom_addr take the value of req_addr and busy go 1, all at that same clock edge.
- R3: Each delay is converted to cycles as ceil(ns / CLK_PERIOD_NS). Let TOT = max(access cycles, select cycles), with a minimum of 1, and LEAD = TOT − strobe cycles, with a minimum of 0. rom_oe_n goes 0 exactly LEAD edges after rom_ce_n went 0.
- R4: rvalid is 1 for exactly one cycle, TOT edges after rom_ce_n went 0. At that edge rdata takes the value present on rom_dq, and it keeps that value until the next capture.
- R5: While rom_ce_n is 0, rom_addr does not change, and rom_oe_n is 0 only while rom_ce_n is 0.
- R6: rom_ce_n and rom_oe_n both return to 1 at the edge after the rvalid edge.
- R7: busy stays 1 for exactly ceil(T_DF_NS / CLK_PERIOD_NS) cycles after the enables rise, and then goes to 0.
- R8: A request raised while busy is 1 is ignored. It produces no rvalid, leaves rom_addr unchanged and does not start a new access after busy falls.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req | input | 1 | Read request, sampled only while idle |
| req_addr | input | ADDR_W | Word address of the request |
| busy | output | 1 | High from acceptance until float recovery ends |
| rdata | output | DATA_W | Captured word |
| rvalid | output | 1 | One-cycle pulse when rdata is updated |
| rom_addr | output | ADDR_W | Address pins of the ROM |
| rom_ce_n | output | 1 | Device select, active low |
| rom_oe_n | output | 1 | Read strobe, active low |
| rom_dq | input | DATA_W | ROM data pins |

## Verification
The bench builds the block with a 10 ns clock and a 120 ns access, 120 ns select, 50 ns strobe and 40 ns float grade. This gives 12 cycles of total wait, a strobe lead of 7 cycles and a float gap of 4 cycles, so the strobe lead, the capture edge and the float gap all fall at different, clearly separated cycles. The bench's ROM model counts how long each pin has been stable and drives a wrong word until every delay is met. A capture one cycle early, or a strobe raised too late, therefore returns wrong data. Random addresses and idle gaps are mixed with requests raised during busy and with the highest and lowest addresses.

// File: rtl/rom_read_ctrl.sv
module rom_read_ctrl #(
  parameter int ADDR_W        = 18,
  parameter int DATA_W        = 16,
  parameter int CLK_PERIOD_NS = 10,
  parameter int T_ACC_NS      = 120,
  parameter int T_CE_NS       = 120,
  parameter int T_OE_NS       = 50,
  parameter int T_DF_NS       = 40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              busy,
  output logic [DATA_W-1:0] rdata,
  output logic              rvalid,
  output logic [ADDR_W-1:0] rom_addr,
  output logic              rom_ce_n,
  output logic              rom_oe_n,
  input  logic [DATA_W-1:0] rom_dq
);
  localparam int ACC_CYC = (T_ACC_NS + CLK_PERIOD_NS - 1) / CLK_PERIOD_NS;
  localparam int CE_CYC  = (T_CE_NS  + CLK_PERIOD_NS - 1) / CLK_PERIOD_NS;
  localparam int OE_CYC  = (T_OE_NS  + CLK_PERIOD_NS - 1) / CLK_PERIOD_NS;
  localparam int DF_CYC  = (T_DF_NS  + CLK_PERIOD_NS - 1) / CLK_PERIOD_NS;
  localparam int TOT_RAW = (ACC_CYC > CE_CYC) ? ACC_CYC : CE_CYC;
  localparam int TOT     = (TOT_RAW < 1) ? 1 : TOT_RAW;
  localparam int LEAD    = (OE_CYC >= TOT) ? 0 : TOT - OE_CYC;
  localparam int CW      = $clog2(TOT + DF_CYC + 2);
  localparam logic [CW-1:0] TOT_M1  = CW'(TOT - 1);
  localparam logic [CW-1:0] LEAD_M1 = CW'((LEAD == 0) ? 0 : LEAD - 1);
  localparam logic [CW-1:0] DF_M1   = CW'((DF_CYC == 0) ? 0 : DF_CYC - 1);

  typedef enum logic [1:0] {S_IDLE, S_ACCESS, S_HOLD, S_FLOAT} state_t;
  state_t        state;
  logic [CW-1:0] cnt;

  assign busy = (state != S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      cnt      <= '0;
      rom_addr <= '0;
      rom_ce_n <= 1'b1;
      rom_oe_n <= 1'b1;
      rdata    <= '0;
      rvalid   <= 1'b0;
    end else begin
      rvalid <= 1'b0;
      case (state)
        S_IDLE: if (req) begin
          state    <= S_ACCESS;
          cnt      <= '0;
          rom_addr <= req_addr;
          rom_ce_n <= 1'b0;
          rom_oe_n <= (LEAD == 0) ? 1'b0 : 1'b1;
        end
        S_ACCESS: begin
          cnt <= cnt + 1'b1;
          if (LEAD != 0 && cnt == LEAD_M1) rom_oe_n <= 1'b0;
          if (cnt == TOT_M1) begin
            rdata  <= rom_dq;
            rvalid <= 1'b1;
            state  <= S_HOLD;
          end
        end
        S_HOLD: begin
          rom_ce_n <= 1'b1;
          rom_oe_n <= 1'b1;
          cnt      <= '0;
          state    <= (DF_CYC == 0) ? S_IDLE : S_FLOAT;
        end
        default: begin
          cnt <= cnt + 1'b1;
          if (cnt == DF_M1) state <= S_IDLE;
        end
      endcase
    end
  end

  assert_strobe_needs_select_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !rom_oe_n |-> !rom_ce_n);
  assert_addr_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!rom_ce_n && $past(!rom_ce_n)) |-> $stable(rom_addr));
  assert_capture_enabled_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rvalid |-> ($past(!rom_ce_n) && $past(!rom_oe_n)));
  assert_valid_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rvalid |=> !rvalid);
  assert_release_after_capture_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rvalid) |-> (rom_ce_n && rom_oe_n));
  assert_float_guard_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (DF_CYC > 0 && $rose(rom_ce_n)) |-> busy);
  assert_select_only_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !rom_ce_n |-> busy);
endmodule

// File: tb/tb_rom_read_ctrl.sv
module tb_rom_read_ctrl;
  localparam int CLK_NS = 10;
  localparam int AW = 18, DW = 16;
  localparam int TACC = 120, TCE = 120, TOE = 50, TDF = 40;
  localparam int C_ACC = (TACC + CLK_NS - 1) / CLK_NS;
  localparam int C_CE  = (TCE + CLK_NS - 1) / CLK_NS;
  localparam int C_OE  = (TOE + CLK_NS - 1) / CLK_NS;
  localparam int C_DF  = (TDF + CLK_NS - 1) / CLK_NS;
  localparam int E_TOT  = (C_ACC > C_CE) ? C_ACC : C_CE;
  localparam int E_LEAD = (C_OE >= E_TOT) ? 0 : E_TOT - C_OE;

  logic clk = 0, rst_n = 0, req = 0;
  logic [AW-1:0] req_addr = '0;
  logic busy, rvalid, rom_ce_n, rom_oe_n;
  logic [DW-1:0] rdata, rom_dq;
  logic [AW-1:0] rom_addr;
  int checks = 0, errors = 0;

  always #(CLK_NS/2) clk = ~clk;

  rom_read_ctrl #(.ADDR_W(AW), .DATA_W(DW), .CLK_PERIOD_NS(CLK_NS), .T_ACC_NS(TACC),
    .T_CE_NS(TCE), .T_OE_NS(TOE), .T_DF_NS(TDF)) dut (
    .clk(clk), .rst_n(rst_n), .req(req), .req_addr(req_addr), .busy(busy),
    .rdata(rdata), .rvalid(rvalid), .rom_addr(rom_addr), .rom_ce_n(rom_ce_n),
    .rom_oe_n(rom_oe_n), .rom_dq(rom_dq));

  function automatic logic [DW-1:0] word_of(input logic [AW-1:0] a);
    return a[15:0] ^ {a[17:16], 14'h0} ^ 16'h5A3C;
  endfunction

  // ROM model: ages count edges since each pin last changed
  int a_age = 0, ce_age = 0, oe_age = 0;
  logic [AW-1:0] last_addr = '0;
  logic last_ce = 1, last_oe = 1;
  always @(negedge clk) begin
    a_age  <= (rom_addr != last_addr) ? 0 : a_age + 1;
    ce_age <= (rom_ce_n != last_ce) ? 0 : ce_age + 1;
    oe_age <= (rom_oe_n != last_oe) ? 0 : oe_age + 1;
    last_addr <= rom_addr; last_ce <= rom_ce_n; last_oe <= rom_oe_n;
  end
  always_comb begin
    if (!rom_ce_n && !rom_oe_n && rom_addr == last_addr && !last_ce && !last_oe &&
        a_age + 1 >= C_ACC && ce_age + 1 >= C_CE && oe_age + 1 >= C_OE)
      rom_dq = word_of(rom_addr);
    else
      rom_dq = 16'hDEAD;
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_read(input logic [AW-1:0] a, input bit noise);
    int oe_t = -1, rv_t = -1, ce_t = -1, bz_t = -1, nrv = 0;
    bit addr_ok = 1;
    logic [DW-1:0] got = '0;
    req = 1; req_addr = a;
    @(negedge clk);
    req = 0;
    check(!rom_ce_n && busy && rom_addr == a, "R2 accept", {rom_ce_n, busy}, 2'b01);
    for (int t = 0; t < E_TOT + C_DF + 4; t++) begin
      if (!rom_ce_n && rom_addr != a) addr_ok = 0;
      if (!rom_oe_n && rom_ce_n) addr_ok = 0;
      if (oe_t < 0 && !rom_oe_n) oe_t = t;
      if (rvalid) begin nrv++; if (rv_t < 0) begin rv_t = t; got = rdata; end end
      if (ce_t < 0 && rom_ce_n) ce_t = t;
      if (bz_t < 0 && !busy) bz_t = t;
      if (noise && t == 2) begin req = 1; req_addr = ~a; end
      else if (noise && t == 3) req = 0;
      @(negedge clk);
    end
    check(oe_t == E_LEAD, "R3 strobe lead", oe_t, E_LEAD);
    check(rv_t == E_TOT, "R4 capture edge", rv_t, E_TOT);
    check(got == word_of(a), "R4 data", got, word_of(a));
    check(rdata == word_of(a), "R4 rdata held", rdata, word_of(a));
    check(addr_ok, "R5 addr/strobe", addr_ok, 1);
    check(ce_t == E_TOT + 1, "R6 release", ce_t, E_TOT + 1);
    check(bz_t == E_TOT + 1 + C_DF, "R7 float gap", bz_t, E_TOT + 1 + C_DF);
    if (noise) check(nrv == 1 && rom_ce_n && !busy, "R8 ignored req", nrv, 1);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        check(rom_ce_n && rom_oe_n && !busy && !rvalid, "R1 reset", {rom_ce_n, rom_oe_n, busy, rvalid}, 4'b1100);
        rst_n = 1;
        @(negedge clk);
        check(rom_ce_n && rom_oe_n && !busy && !rvalid, "R1 after reset", {rom_ce_n, rom_oe_n, busy, rvalid}, 4'b1100);
        do_read('0, 0);
        do_read('1, 1);
        do_read(18'h20001, 1);
        void'($urandom(32'h1234));
        for (int i = 0; i < 40; i++) begin
          int gap = $urandom_range(0, 3);
          repeat (gap) @(negedge clk);
          do_read(AW'($urandom), $urandom_range(0, 1) == 1);
        end
      end
      begin
        repeat (20000) @(posedge clk);
        check(0, "watchdog", 0, 1);
      end
    join_any
    disable fork;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule